// File: doc/BRIEF.md
# Multi-Memory Zero-Initialization Sequencer

This block clears a set of on-chip RAM arrays to zero after software asks for it. Software chooses the memories through a select mask and a bank sub-select. It then writes a key value into a control register to start the sequence. The sequencer visits each chosen memory in turn and writes an all-zero data word to every address. Each write carries check bits that match that memory's protection scheme, so later reads of the cleared words raise no error. A status register shows when the sequence is running and when it has completed.

Six memories are modelled:

| Index | Words | Scheme |
|-------|-------|--------|
| 0 | 64 | SECDED |
| 1 | 128 | SECDED |
| 2 | 64 | even parity |
| 3 | 256 | odd parity |
| 4 | 64 | even parity |
| 5 | 128 | odd parity |

Memories 0 and 1 are two banks in separate power domains. They share one select bit, and the bank sub-select decides which of the two is cleared. Memories 4 and 5 belong to peripherals that run their own local clear when they leave reset. The sequencer holds at such a memory until its owner is out of reset and reports its local clear as finished. It never skips that memory.

All memories share one write address and data bus. Each memory has its own write strobe.

Top module: `meminit_seq`

## Requirements
- R1: The sequence starts only on a write to the control register (address 0) whose bits [3:0] equal 4'hA while idle. Any other value leaves busy low and causes no memory write. Bits [3:0] of the control register read back as last written.
- R2: The select register (address 1) has five bits. Bit 0 selects the bank pair (memories 0 and 1), and bits 1 to 4 select memories 2 to 5. A memory whose selection is off receives no write.
- R3: The bank sub-select register (address 2) enables memory 0 with bit 0 and memory 1 with bit 1. Memory 0 is cleared only when select bit 0 and sub-select bit 0 are both set. Memory 1 is cleared only when select bit 0 and sub-select bit 1 are both set.
- R4: Every word of a selected memory is written exactly once, with zero data, in ascending address order from 0 to depth-1. The depths are 64, 128, 64, 256, 64 and 128 for memories 0 to 5.
- R5: The check output has 7 bits.
  - Even parity: bit k is the XOR of data byte k, with bits 6:4 at zero. For zero data this gives 7'h00.
  - Odd parity: bit k is the inverted XOR of data byte k, with bits 6:4 at zero. For zero data this gives 7'h0F.
  - SECDED: a Hamming code over positions 1 to 38 with check bits at the power-of-two positions, plus an overall parity in bit 6. For zero data this gives 7'h00.
- R6: Memories are processed one at a time in ascending index order. At most one write strobe is high in any cycle.
- R7: Memory 4 (slot 0) and memory 5 (slot 1) receive writes only while that slot's out-of-reset input is 1 and its local-busy input is 0. Otherwise the sequencer stalls there with busy high.
- R8: Status (address 3) shows busy in bit 0 and done in bit 1, and the two are never high together. Done sets when the last selected word is written. A starting key write clears done.
- R9: Writes to the select, sub-select and control registers while busy are ignored.
- R10: A start whose effective selection is empty sets done in the next cycle, keeps busy low and writes nothing.
- R11: After reset, busy, done and all registers are zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sc_out_of_reset | input | 2 | Self-clearing owners released from reset |
| sc_busy | input | 2 | Self-clearing owners' local clear in progress |
| mem_we | output | 6 | Per-memory write strobe |
| mem_addr | output | 8 | Shared word address |
| mem_wdata | output | 32 | Shared write data |
| mem_wcheck | output | 7 | Check bits for the active memory's scheme |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence completed |

## Verification
The assertions check the following on every cycle:
- at most one write strobe is high, and strobes never go back to a lower memory index;
- written data is zero;
- addresses stay below each memory's depth and step by one within a memory;
- self-clearing memories are never written while their owner is in reset or still clearing;
- busy and done are never high together.

Only the bench scenarios can show the rest:
- that every word of exactly the selected memories ends up zero with correct check bits;
- that unselected memories keep their old contents;
- that a stall releases and completes;
- that writes made while busy leave the registers unchanged.

// File: rtl/meminit_pkg.sv
package meminit_pkg;
    localparam int NUM_MEM = 6;
    localparam int NUM_SEL = 5;
    localparam int NUM_SC  = 2;
    localparam int DATA_W  = 32;
    localparam int CHK_W   = 7;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = $clog2(NUM_MEM + 1);
    localparam int KEY_W   = 4;

    typedef enum logic [1:0] {SCH_EVEN, SCH_ODD, SCH_SECDED} scheme_e;

    localparam int unsigned MEM_DEPTH [NUM_MEM] = '{64, 128, 64, 256, 64, 128};
    localparam scheme_e MEM_SCHEME [NUM_MEM] =
        '{SCH_SECDED, SCH_SECDED, SCH_EVEN, SCH_ODD, SCH_EVEN, SCH_ODD};
    // owner slot of a self-clearing memory, -1 when the memory has none
    localparam int MEM_SC_SLOT [NUM_MEM] = '{-1, -1, -1, -1, 0, 1};

    localparam logic [KEY_W-1:0] INIT_KEY = 4'hA;
    localparam logic [1:0] RA_CTRL   = 2'd0;
    localparam logic [1:0] RA_SEL    = 2'd1;
    localparam logic [1:0] RA_BANK   = 2'd2;
    localparam logic [1:0] RA_STATUS = 2'd3;

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [IDX_W-1:0]   cur;
        logic [ADDR_W-1:0]  addr;
        logic [KEY_W-1:0]   ctrl;
        logic [NUM_SEL-1:0] sel;
        logic [1:0]         bank;
    } state_t;
endpackage

// File: rtl/meminit_check_gen.sv
module meminit_check_gen
    import meminit_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  scheme_e        scheme,
    input  logic [DW-1:0]  data,
    output logic [CW-1:0]  check
);
    localparam int NB = DW / 8;

    logic [NB-1:0] byte_par;
    logic [CW-1:0] ecc;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            byte_par[b] = ^data[b*8 +: 8];
        end
    end

    // Hamming over positions that are not powers of two, overall parity on top
    always_comb begin
        int pos;
        ecc = '0;
        pos = 1;
        for (int k = 0; k < DW; k++) begin
            pos = pos + 1;
            while ((pos & (pos - 1)) == 0) pos = pos + 1;
            for (int j = 0; j < CW - 1; j++) begin
                if (((pos >> j) & 1) == 1) ecc[j] = ecc[j] ^ data[k];
            end
        end
        ecc[CW-1] = (^data) ^ (^ecc[CW-2:0]);
    end

    always_comb begin
        unique case (scheme)
            SCH_EVEN:   check = {{(CW-NB){1'b0}}, byte_par};
            SCH_ODD:    check = {{(CW-NB){1'b0}}, ~byte_par};
            default:    check = ecc;
        endcase
    end
endmodule

// File: rtl/meminit_pick.sv
module meminit_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] from,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit of mask at or above index "from"
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/meminit_seq.sv
module meminit_seq
    import meminit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_SC-1:0]    sc_out_of_reset,
    input  logic [NUM_SC-1:0]    sc_busy,
    output logic [NUM_MEM-1:0]   mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [CHK_W-1:0]     mem_wcheck,
    output logic                 busy,
    output logic                 done
);
    state_t s_q, s_d;

    logic [NUM_MEM-1:0] mem_en;
    logic [NUM_MEM-1:0] mem_ready;
    logic [NUM_MEM-1:0] at_last;
    logic               first_found, next_found;
    logic [IDX_W-1:0]   first_idx, next_idx;
    logic               key_hit;
    logic               cur_ready, cur_last;
    scheme_e            cur_scheme;

    // effective enable, readiness and end-of-memory per memory
    for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
        if (i < 2) begin : g_bank
            assign mem_en[i] = s_q.sel[0] & s_q.bank[i];
        end else begin : g_plain
            assign mem_en[i] = s_q.sel[i-1];
        end
        if (MEM_SC_SLOT[i] >= 0) begin : g_sc
            assign mem_ready[i] = sc_out_of_reset[MEM_SC_SLOT[i]] & ~sc_busy[MEM_SC_SLOT[i]];
        end else begin : g_nsc
            assign mem_ready[i] = 1'b1;
        end
        assign at_last[i] = (s_q.addr == ADDR_W'(MEM_DEPTH[i] - 1));
        assign mem_we[i]  = s_q.busy && (s_q.cur == IDX_W'(i)) && mem_ready[i];
    end

    meminit_pick #(.N(NUM_MEM), .IW(IDX_W)) u_pick_first (
        .mask(mem_en), .from('0), .found(first_found), .idx(first_idx)
    );
    meminit_pick #(.N(NUM_MEM), .IW(IDX_W)) u_pick_next (
        .mask(mem_en), .from(s_q.cur + 1'b1), .found(next_found), .idx(next_idx)
    );

    always_comb begin
        cur_ready  = 1'b0;
        cur_last   = 1'b0;
        cur_scheme = SCH_EVEN;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (s_q.cur == IDX_W'(i)) begin
                cur_ready  = mem_ready[i];
                cur_last   = at_last[i];
                cur_scheme = MEM_SCHEME[i];
            end
        end
    end

    meminit_check_gen #(.DW(DATA_W), .CW(CHK_W)) u_check (
        .scheme(cur_scheme), .data(mem_wdata), .check(mem_wcheck)
    );

    assign key_hit = reg_we && (reg_addr == RA_CTRL) && (reg_wdata[KEY_W-1:0] == INIT_KEY);

    always_comb begin
        s_d = s_q;
        if (reg_we && !s_q.busy) begin
            unique case (reg_addr)
                RA_CTRL: s_d.ctrl = reg_wdata[KEY_W-1:0];
                RA_SEL:  s_d.sel  = reg_wdata[NUM_SEL-1:0];
                RA_BANK: s_d.bank = reg_wdata[1:0];
                default: ;
            endcase
        end
        if (key_hit && !s_q.busy) begin
            s_d.addr = '0;
            s_d.cur  = first_idx;
            s_d.busy = first_found;
            s_d.done = !first_found;
        end else if (s_q.busy && cur_ready) begin
            if (!cur_last) begin
                s_d.addr = s_q.addr + 1'b1;
            end else if (next_found) begin
                s_d.cur  = next_idx;
                s_d.addr = '0;
            end else begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {{(32-KEY_W){1'b0}}, s_q.ctrl};
            RA_SEL:  reg_rdata = {{(32-NUM_SEL){1'b0}}, s_q.sel};
            RA_BANK: reg_rdata = {30'b0, s_q.bank};
            default: reg_rdata = {30'b0, s_q.done, s_q.busy};
        endcase
    end

    assign mem_addr  = s_q.addr;
    assign mem_wdata = '0;
    assign busy      = s_q.busy;
    assign done      = s_q.done;
endmodule

// File: rtl/meminit_seq_chk.sv
module meminit_seq_chk
    import meminit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SC-1:0]  sc_out_of_reset,
    input logic [NUM_SC-1:0]  sc_busy,
    input logic [NUM_MEM-1:0] mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               busy,
    input logic               done
);
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_we));

    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we != '0) && ($past(mem_we) != '0)) |-> (mem_we >= $past(mem_we)));

    assert_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> (mem_wdata == '0));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we != '0) && (mem_we == $past(mem_we))) |-> (mem_addr == $past(mem_addr) + 1'b1));

    assert_write_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |-> busy);

    assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    for (genvar i = 0; i < NUM_MEM; i++) begin : g_chk
        assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we[i] |-> (32'(mem_addr) < MEM_DEPTH[i]));
        if (MEM_SC_SLOT[i] >= 0) begin : g_sc
            assert_sc_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
                mem_we[i] |-> (sc_out_of_reset[MEM_SC_SLOT[i]] && !sc_busy[MEM_SC_SLOT[i]]));
        end
    end
endmodule

bind meminit_seq meminit_seq_chk u_chk (.*);

// File: tb/meminit_seq_test.sv
module meminit_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  sc_out_of_reset = 2'b11;
    logic [1:0]  sc_busy = 2'b00;
    logic [5:0]  mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [6:0]  mem_wcheck;
    logic        busy, done;

    int checks = 0;
    int errors = 0;

    localparam int DEPTH [6] = '{64, 128, 64, 256, 64, 128};
    localparam int KIND  [6] = '{2, 2, 0, 1, 0, 1};   // 0 even, 1 odd, 2 secded

    logic [31:0] bd   [6][256];
    logic [6:0]  bc   [6][256];
    logic [31:0] pre_d[6][256];
    logic [6:0]  pre_c[6][256];
    int wcount [6];
    int last_mem = -1;
    bit order_bad = 1'b0;

    always #2.5 clk = ~clk;

    meminit_seq uut (.*);

    // memory model: record each cycle's write half a period before it lands
    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            if (mem_we[i]) begin
                bd[i][mem_addr] = mem_wdata;
                bc[i][mem_addr] = mem_wcheck;
                wcount[i]++;
                if (i < last_mem) order_bad = 1'b1;
                last_mem = i;
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [6:0] exp_chk(int kind, logic [31:0] d);
        logic [6:0] c = '0;
        int p = 2;
        if (kind < 2) begin
            for (int b = 0; b < 4; b++) c[b] = (^d[b*8 +: 8]) ^ (kind == 1);
            return c;
        end
        for (int k = 0; k < 32; k++) begin
            p++;
            if (p == 4 || p == 8 || p == 16 || p == 32) p++;
            if (d[k]) c[5:0] = c[5:0] ^ p[5:0];
        end
        c[6] = (^d) ^ (^c[5:0]);
        return c;
    endfunction

    function automatic logic [5:0] eff_mask(logic [4:0] s, logic [1:0] b);
        return {s[4:1], s[0] & b[1], s[0] & b[0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic preload();
        for (int i = 0; i < 6; i++) begin
            wcount[i] = 0;
            for (int a = 0; a < 256; a++) begin
                pre_d[i][a] = $urandom | 32'h1;
                pre_c[i][a] = 7'($urandom);
                bd[i][a] = pre_d[i][a];
                bc[i][a] = pre_c[i][a];
            end
        end
        last_mem = -1;
        order_bad = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_mems(logic [5:0] m);
        for (int i = 0; i < 6; i++) begin
            int bad = 0;
            logic [31:0] ad = '0, ed = '0;
            for (int a = 0; a < DEPTH[i]; a++) begin
                logic [31:0] xd = m[i] ? 32'h0 : pre_d[i][a];
                logic [6:0]  xc = m[i] ? exp_chk(KIND[i], 32'h0) : pre_c[i][a];
                if (bad == 0 && (bd[i][a] !== xd || bc[i][a] !== xc)) begin
                    bad = 1;
                    ad = {bc[i][a], 25'b0} ^ bd[i][a];
                    ed = {xc, 25'b0} ^ xd;
                end
            end
            if (m[i]) check("R5 contents of cleared memory", ad, ed);
            else      check("R2 unselected memory untouched", ad, ed);
            check("R4 write count per memory", wcount[i], m[i] ? DEPTH[i] : 0);
        end
        check("R6 ascending memory order", order_bad, 0);
    endtask

    task automatic full_run(logic [4:0] s, logic [1:0] b);
        preload();
        reg_write(2'd2, {30'b0, b});
        reg_write(2'd1, {27'b0, s});
        reg_write(2'd0, 32'hA);
        wait_done();
        check("R8 done after run", {busy, done}, 2'b01);
        check_mems(eff_mask(s, b));
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h5EED));
        preload();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset status", {busy, done}, 2'b00);
        check("R11 no strobe after reset", mem_we, 0);
        reg_read(2'd1, rd);
        check("R11 select reset value", rd, 0);

        // R1: non-key value does not start
        reg_write(2'd1, 32'h1F);
        reg_write(2'd2, 32'h3);
        reg_write(2'd0, 32'h5);
        repeat (4) @(negedge clk);
        check("R1 wrong key leaves idle", {busy, done}, 2'b00);
        check("R1 wrong key writes nothing", wcount[3], 0);
        reg_read(2'd0, rd);
        check("R1 control readback", rd, 32'h5);

        // R10: empty selection, and R3 bank bit gating to empty
        preload();
        reg_write(2'd1, 32'h0);
        reg_write(2'd0, 32'hA);
        @(negedge clk);
        check("R10 zero mask done next cycle", {busy, done}, 2'b01);
        preload();
        reg_write(2'd2, 32'h0);
        reg_write(2'd1, 32'h1);
        reg_write(2'd0, 32'hA);
        @(negedge clk);
        check("R10 R3 bank sub-select empty", {busy, done}, 2'b01);
        repeat (3) @(negedge clk);
        check_mems(6'b0);

        // directed: everything, then single banks
        full_run(5'h1F, 2'b11);
        full_run(5'h01, 2'b10);
        full_run(5'h01, 2'b01);

        // random selections with fixed seed
        for (int r = 0; r < 5; r++) begin
            full_run(5'($urandom), 2'($urandom));
        end

        // R7 stall on self-clearing memory 4, R9 writes while busy
        preload();
        sc_out_of_reset = 2'b10;
        sc_busy = 2'b00;
        reg_write(2'd2, 32'h0);
        reg_write(2'd1, 32'h0A);
        reg_write(2'd0, 32'hA);
        repeat (150) @(negedge clk);
        check("R7 stall while owner in reset", {busy, done}, 2'b10);
        check("R7 no write while owner in reset", wcount[4], 0);
        check("R7 earlier memory finished", wcount[2], 64);
        sc_out_of_reset = 2'b11;
        sc_busy = 2'b01;
        reg_write(2'd1, 32'h1F);
        reg_write(2'd2, 32'h3);
        reg_write(2'd0, 32'h3);
        reg_read(2'd1, rd);
        check("R9 select ignored while busy", rd, 32'h0A);
        reg_read(2'd2, rd);
        check("R9 sub-select ignored while busy", rd, 32'h0);
        reg_read(2'd0, rd);
        check("R9 control ignored while busy", rd, 32'hA);
        repeat (100) @(negedge clk);
        check("R7 no write while owner clearing", wcount[4], 0);
        sc_busy = 2'b00;
        wait_done();
        check("R7 completes after release", {busy, done}, 2'b01);
        check_mems(6'b010100);

        // R8 done clears on new start
        reg_write(2'd1, 32'h02);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hA;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd3; #1;
        check("R8 start clears done", reg_rdata, 32'h1);
        wait_done();
        check("R8 status done", {busy, done}, 2'b01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule